// File: doc/BRIEF.md
# Nine-Square Three-in-a-Row Detector

This block looks at a three-by-three game board and finds out whether any player has filled a complete line. Each square holds a one-hot player code, and an empty square holds zero. A board is handed over with a valid/ready handshake. The block copies the board into its own register and then scans it serially, one square per clock.

Every square owns a fixed 8-bit line mask. A bit in that mask is cleared for each of the eight winning lines that pass through the square. For one candidate player value, an accumulator starts at all ones. Each square that does not hold exactly that value ANDs its mask into the accumulator. If any bit is still set after the ninth square, the candidate owns a line. Candidates are tried from code bit 0 upward, and the scan stops at the first candidate that wins.

When the scan ends, a one-cycle `done` pulse is raised and the result is presented. The result stays on its pins until the next scan ends. The result side has no back-pressure. Input back-pressure comes only from `in_ready`, which is low for the whole scan.

Top module: `ttt_line_detect`

## Requirements
- R1: `in_ready` is high whenever no scan is running. A board is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` then stays low until the scan ends, and `in_valid` has no effect while it is low.
- R2: Square i sits at `in_board[i*PW +: PW]`. Squares run row by row: 0,1,2 is the top row, 3,4,5 the middle row and 6,7,8 the bottom row. The eight lines are the three rows, the three columns, and the diagonals 0-4-8 and 2-4-6.
- R3: A one-hot value v wins only when all three squares of some line hold exactly v.
- R4: A square holding zero (empty), or holding a value with more than one bit set, never contributes to a win.
- R5: Candidate values are tried from bit 0 upward. When several values own lines, the one with the lowest bit is reported.
- R6: `done` is high for exactly one cycle, 9*k clock edges after the accepting edge. k is the winning bit index plus one, or PW when there is no win.
- R7: In the `done` cycle, `win_found` shows whether a line exists and `win_player` carries the winning one-hot value, or zero when there is none. Both stay unchanged until the next `done`.
- R8: The board is captured at the accepting edge. Changes on `in_board` during a scan do not affect its result.
- R9: After reset, `in_ready` is 1 and `done`, `win_found` and `win_player` are 0.
- R10: A new board may be accepted at the edge right after `done`, which gives back-to-back scans.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Board offered |
| in_ready | output | 1 | Idle, so a board can be taken |
| in_board | input | 9*PW | Nine square codes, square 0 in the low bits |
| done | output | 1 | One-cycle pulse when a scan ends |
| win_found | output | 1 | A line exists on the last board scanned |
| win_player | output | PW | One-hot winning value, or zero |

## Verification
The checker assumes that reset is asserted from time zero. It places no rule on `in_valid` or `in_board`: the block must ignore both while it is busy. The result checks only require that the scan length counted from acceptance is a whole number of nine-square passes and is no longer than PW passes.

The stimulus deliberately holds `in_valid` high and changes `in_board` during scans. It builds boards from a small set of codes that includes empty squares, the top code bit and a two-bit code. It also sends back-to-back boards so that acceptance lands on the edge right after `done`.

// File: rtl/ttt_pkg.sv
package ttt_pkg;
  localparam int NSQ   = 9;
  localparam int NLINE = 8;

  // A cleared bit marks a line passing through the square.
  // Line bits: 7..5 rows, 4..2 columns, 1 main diagonal, 0 anti-diagonal.
  function automatic logic [NLINE-1:0] sq_line_mask(input int idx);
    case (idx)
      0:       return 8'b0110_1101;
      1:       return 8'b0111_0111;
      2:       return 8'b0111_1010;
      3:       return 8'b1010_1111;
      4:       return 8'b1011_0100;
      5:       return 8'b1011_1011;
      6:       return 8'b1100_1110;
      7:       return 8'b1101_0111;
      8:       return 8'b1101_1001;
      default: return '1;
    endcase
  endfunction
endpackage

// File: rtl/ttt_square_sel.sv
module ttt_square_sel
  import ttt_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic [NSQ*PW-1:0] board,
  input  logic [3:0]        sq_idx,
  output logic [PW-1:0]     sq_val,
  output logic [NLINE-1:0]  sq_mask
);
  logic [PW-1:0]    vals  [NSQ];
  logic [NLINE-1:0] masks [NSQ];

  for (genvar g = 0; g < NSQ; g++) begin : g_sq
    assign vals[g]  = board[g*PW +: PW];
    assign masks[g] = sq_line_mask(g);
  end

  always_comb begin
    sq_val  = '0;
    sq_mask = '1;
    for (int i = 0; i < NSQ; i++) begin
      if (sq_idx == 4'(i)) begin
        sq_val  = vals[i];
        sq_mask = masks[i];
      end
    end
  end
endmodule

// File: rtl/ttt_line_acc.sv
module ttt_line_acc
  import ttt_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             first_sq,
  input  logic [PW-1:0]    sq_val,
  input  logic [PW-1:0]    cand,
  input  logic [NLINE-1:0] sq_mask,
  output logic             any_line
);
  logic [NLINE-1:0] acc_q, acc_cur, acc_nxt;

  always_comb begin
    acc_cur  = first_sq ? '1 : acc_q;
    acc_nxt  = (sq_val == cand) ? acc_cur : (acc_cur & sq_mask);
    any_line = |acc_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     acc_q <= '1;
    else if (step)  acc_q <= acc_nxt;
  end
endmodule

// File: rtl/ttt_scan_ctrl.sv
module ttt_scan_ctrl
  import ttt_pkg::*;
#(
  parameter int PW = 8,
  localparam int BW = (PW > 1) ? $clog2(PW) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          any_line,
  output logic          busy,
  output logic          first_sq,
  output logic          finish,
  output logic [3:0]    sq_idx,
  output logic [PW-1:0] cand
);
  logic [BW-1:0] bit_idx;
  logic          last_sq, last_bit;

  assign last_sq  = (sq_idx == 4'(NSQ-1));
  assign last_bit = (bit_idx == BW'(PW-1));
  assign first_sq = (sq_idx == 4'd0);
  assign finish   = busy && last_sq && (any_line || last_bit);
  assign cand     = {{(PW-1){1'b0}}, 1'b1} << bit_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sq_idx  <= '0;
      bit_idx <= '0;
    end else if (!busy) begin
      if (accept) begin
        busy    <= 1'b1;
        sq_idx  <= '0;
        bit_idx <= '0;
      end
    end else if (last_sq) begin
      sq_idx <= '0;
      if (any_line || last_bit) busy    <= 1'b0;
      else                      bit_idx <= bit_idx + 1'b1;
    end else begin
      sq_idx <= sq_idx + 4'd1;
    end
  end
endmodule

// File: rtl/ttt_line_detect.sv
module ttt_line_detect
  import ttt_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [NSQ*PW-1:0] in_board,
  output logic              done,
  output logic              win_found,
  output logic [PW-1:0]     win_player
);
  logic              busy, first_sq, finish, any_line, accept;
  logic [3:0]        sq_idx;
  logic [PW-1:0]     cand, sq_val;
  logic [NLINE-1:0]  sq_mask;
  logic [NSQ*PW-1:0] board_q;

  assign in_ready = !busy;
  assign accept   = in_valid && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n)      board_q <= '0;
    else if (accept) board_q <= in_board;
  end

  ttt_scan_ctrl #(.PW(PW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .accept(accept), .any_line(any_line),
    .busy(busy), .first_sq(first_sq), .finish(finish),
    .sq_idx(sq_idx), .cand(cand)
  );

  ttt_square_sel #(.PW(PW)) u_sel (
    .board(board_q), .sq_idx(sq_idx), .sq_val(sq_val), .sq_mask(sq_mask)
  );

  ttt_line_acc #(.PW(PW)) u_acc (
    .clk(clk), .rst_n(rst_n), .step(busy), .first_sq(first_sq),
    .sq_val(sq_val), .cand(cand), .sq_mask(sq_mask), .any_line(any_line)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done       <= 1'b0;
      win_found  <= 1'b0;
      win_player <= '0;
    end else begin
      done <= finish;
      if (finish) begin
        win_found  <= any_line;
        win_player <= any_line ? cand : '0;
      end
    end
  end
endmodule

// File: rtl/ttt_line_detect_chk.sv
module ttt_line_detect_chk #(
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          done,
  input logic          win_found,
  input logic [PW-1:0] win_player
);
  logic accept;
  logic act;
  int   cnt;

  assign accept = in_valid && in_ready;

  // Counts cycles since acceptance, so the scan window needs no long $past.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act <= 1'b0;
      cnt <= 0;
    end else if (accept) begin
      act <= 1'b1;
      cnt <= 0;
    end else if (act && !done) begin
      cnt <= cnt + 1;
    end else if (done) begin
      act <= 1'b0;
    end
  end

  assert_ready_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);
  assert_idle_at_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (act && cnt != 0 && (cnt % 9) == 0 && cnt <= 9*PW));
  assert_result_coded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_player) && (win_found == (win_player != '0)));
  assert_result_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> ($stable(win_found) && $stable(win_player)) || done);
endmodule

bind ttt_line_detect ttt_line_detect_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .done(done), .win_found(win_found), .win_player(win_player)
);

// File: tb/test_ttt_line_detect.sv
module test_ttt_line_detect;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;
  localparam int NB = 9*PW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [NB-1:0] in_board = '0;
  logic          done, win_found;
  logic [PW-1:0] win_player;

  int    vectors = 0, miscompares = 0;
  string cur_req = "R9";

  // reference state
  bit          exp_ready = 1, exp_done = 0, exp_wf = 0, pend_wf = 0;
  logic [PW-1:0] exp_wp = '0, pend_wp = '0;
  int          exp_cnt = 0;

  ttt_line_detect #(.PW(PW)) i_ttt_line_detect (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_board(in_board), .done(done), .win_found(win_found), .win_player(win_player)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int sq(logic [NB-1:0] b, int i);
    return int'(b[i*PW +: PW]);
  endfunction

  // lowest winning bit index, or -1 (R2, R3, R4, R5)
  function automatic int ref_win(logic [NB-1:0] b);
    int ln [8][3];
    for (int r = 0; r < 3; r++) begin
      ln[r][0] = 3*r; ln[r][1] = 3*r+1; ln[r][2] = 3*r+2;
      ln[3+r][0] = r; ln[3+r][1] = r+3; ln[3+r][2] = r+6;
    end
    ln[6][0] = 0; ln[6][1] = 4; ln[6][2] = 8;
    ln[7][0] = 2; ln[7][1] = 4; ln[7][2] = 6;
    for (int p = 0; p < PW; p++)
      for (int l = 0; l < 8; l++)
        if (sq(b, ln[l][0]) == (1 << p) && sq(b, ln[l][1]) == (1 << p) &&
            sq(b, ln[l][2]) == (1 << p))
          return p;
    return -1;
  endfunction

  function automatic logic [NB-1:0] mk(int s0, int s1, int s2, int s3, int s4,
                                       int s5, int s6, int s7, int s8);
    logic [NB-1:0] b;
    int s[9];
    s = '{s0, s1, s2, s3, s4, s5, s6, s7, s8};
    b = '0;
    for (int i = 0; i < 9; i++) b[i*PW +: PW] = PW'(s[i]);
    return b;
  endfunction

  task automatic chk(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    bit            acc, rs;
    logic [NB-1:0] b;
    int            p;
    acc = in_valid && exp_ready;
    rs  = rst_n;
    b   = in_board;
    @(posedge clk);
    @(negedge clk);
    if (!rs) begin
      exp_ready = 1; exp_done = 0; exp_wf = 0; exp_wp = '0; exp_cnt = 0;
    end else begin
      exp_done = 0;
      if (exp_cnt > 0) begin
        exp_cnt--;
        if (exp_cnt == 0) begin
          exp_done = 1; exp_ready = 1; exp_wf = pend_wf; exp_wp = pend_wp;
        end
      end
      if (acc) begin
        p = ref_win(b);
        exp_ready = 0;
        exp_cnt   = 9 * ((p < 0) ? PW : p + 1);
        pend_wf   = (p >= 0);
        pend_wp   = (p >= 0) ? PW'(1 << p) : '0;
      end
    end
    chk("in_ready", int'(in_ready), int'(exp_ready));
    chk("done", int'(done), int'(exp_done));
    chk("win_found", int'(win_found), int'(exp_wf));
    chk("win_player", int'(win_player), int'(exp_wp));
  endtask

  task automatic run_board(logic [NB-1:0] b, string req);
    cur_req  = req;
    in_board = b;
    in_valid = 1'b1;
    step();
    in_valid = 1'b0;
    for (int i = 0; i < 9*PW + 2 && !exp_done; i++) step();
    step();
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    miscompares++;
    $display("FAIL R6 watchdog: actual hang expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    @(negedge clk);
    cur_req = "R9";                 // reset state
    for (int i = 0; i < 3; i++) step();
    rst_n = 1'b1;
    step();

    run_board(mk(0,0,0,0,0,0,0,0,0), "R4_empty");
    run_board(mk(1,1,1,2,2,0,0,0,0), "R3_row_value1");
    run_board(mk(1,2,0,1,2,0,0,2,1), "R2_column_value2");
    run_board(mk(8,1,2,0,8,1,2,0,8), "R2_diag_value8");
    run_board(mk(1,1,128,2,128,1,128,2,2), "R6_antidiag_topbit");
    run_board(mk(4,4,4,1,1,1,0,0,0), "R5_priority_low_bit");
    run_board(mk(1,2,1,1,2,2,2,1,1), "R6_draw_full_scan");
    run_board(mk(3,3,3,0,0,0,0,0,0), "R4_multi_bit_code");
    run_board(mk(0,2,0,0,2,0,0,2,0), "R3_middle_column");

    // R8 / R1: board changes and valid held during a scan
    cur_req  = "R8_latched_board";
    in_board = mk(2,2,2,0,0,0,0,0,0);
    in_valid = 1'b1;
    step();
    in_board = mk(1,1,1,0,0,0,0,0,0);
    for (int i = 0; i < 5; i++) step();
    in_valid = 1'b0;
    for (int i = 0; i < 9*PW + 2 && !exp_done; i++) step();
    step();

    // R10: valid stays high, next board taken right after done
    cur_req  = "R10_back_to_back";
    in_board = mk(0,0,0,16,16,16,0,0,0);
    in_valid = 1'b1;
    step();
    for (int i = 0; i < 9*PW + 2 && !exp_done; i++) step();
    in_board = mk(64,0,0,64,0,0,64,0,0);
    step();
    in_valid = 1'b0;
    for (int i = 0; i < 9*PW + 2 && !exp_done; i++) step();
    step();

    // R3 / R5 / R6: random boards from a small code set
    for (int n = 0; n < 40; n++) begin
      int codes[7];
      logic [NB-1:0] b;
      codes = '{0, 1, 2, 4, 8, 128, 3};
      b = '0;
      for (int i = 0; i < 9; i++) b[i*PW +: PW] = PW'(codes[$urandom_range(6)]);
      run_board(b, "R3_R5_random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule